// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block is the data path of an 8-bit SPI master. A host sees three registers: a transmit buffer, a receive buffer and a combined control/status word. Writing the transmit buffer while the engine is idle starts a transfer. The byte is shifted out on `sdo` while `sdi` is shifted in. The serial clock is the system clock divided by two, in SPI mode 0: data changes while the serial clock falls and is sampled while it rises.

After the eighth bit has been sampled, the engine holds the line idle for a programmable settle time of 8, 16, 24 or 32 system clocks. At the end of that time it copies the received byte into the receive buffer and raises a full flag. Reading the receive buffer clears the flag. Three settings are captured when a transfer starts and stay fixed until it ends: the bit order, the settle time, and whether `sdo` is push-pull or open-drain.

Register addresses on `host_addr`: 0 = receive buffer (read), 1 = transmit buffer (read/write), 2 = control/status (read/write). Reads are combinational on `host_rdata`.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, `busy`=0, `sclk`=0, `sdo`=1, `sdo_oe`=1 and `rx_full`=0, and both the control/status word and the receive buffer read as 0.
- R2: A write to address 1 while idle starts a transfer. `busy` is 1 from the edge that takes the write until the edge that samples the eighth bit, which is the 15th edge after the write edge; after that edge `busy` is 0.
- R3: `sclk` is low at the write edge and toggles on every following edge while shifting, giving 8 rising edges. `sdo` changes only on edges that leave `sclk` low. `sclk` is low whenever the engine is not shifting.
- R4: Control bit 7 selects the bit order. 0 sends and receives MSB first; 1 sends and receives LSB first. The received byte keeps its natural bit weights in either order.
- R5: Control bits 6:5 select the settle time: 00, 01, 10 and 11 give 8, 16, 24 and 32 system clocks. Completion occurs that many edges after the eighth-bit sample edge. During the settle time `sdo`=1 and `sclk`=0.
- R6: On completion the received byte appears at address 0, and both status bit 0 and `rx_full` become 1.
- R7: A read of address 0 with `host_rd`=1 clears status bit 0 and `rx_full` at the next edge. If completion happens in the same cycle, the set wins.
- R8: Control bit 3 = 1 selects open-drain: `sdo_oe` = NOT `sdo`, so the pin is driven only when low. Control bit 3 = 0 selects push-pull: `sdo_oe` is held at 1.
- R9: A write to address 1 during a transfer, including the settle time, is ignored. The buffer reads back its original byte and the byte on the wire is unchanged.
- R10: Status bits 4, 2 and 1 always read 0. Bits 7, 6, 5 and 3 read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (needed to clear the full flag) |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock, system clock / 2 |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad |
| busy | output | 1 | Bits are being shifted |
| rx_full | output | 1 | Receive buffer holds an unread byte |

## Verification
The hardest case to reach from the ports is a write that arrives while a transfer is still running. This matters most during the settle time, when `busy` is already low but the engine is not yet idle. The stimulus task injects a conflicting write at the fourth bit and another one during the settle time. It then checks three things: the bits on the wire, the received byte, and the transmit-buffer readback. Every settle-time code is run, and the full flag is sampled at the last edge before completion and again at the completion edge.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_RXBUF = 2'd0;
  localparam logic [ADDR_W-1:0] A_TXBUF = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;

  // control/status bit positions
  localparam int unsigned CB_ORDER  = 7;
  localparam int unsigned CB_DLY_HI = 6;
  localparam int unsigned CB_DLY_LO = 5;
  localparam int unsigned CB_OD     = 3;
  localparam int unsigned CB_FULL   = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } eng_state_t;

  typedef struct packed {
    logic       lsb_first;
    logic [1:0] dly_sel;
    logic       open_drain;
  } eng_cfg_t;

endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_eng_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic              eng_idle,
  input  logic              xfer_done,
  input  logic [DW-1:0]     rx_byte,
  output logic              start,
  output logic [DW-1:0]     tx_byte,
  output eng_cfg_t          cfg,
  output logic              rx_full
);

  logic [DW-1:0] txbuf_q, rxbuf_q;
  eng_cfg_t      cfg_q, cfg_d;
  logic          full_q, full_d;
  logic          wr_tx, wr_ctl, rd_rx, full_en;

  always_comb begin
    wr_tx   = host_wr && (host_addr == A_TXBUF);
    wr_ctl  = host_wr && (host_addr == A_CTRL);
    rd_rx   = host_rd && (host_addr == A_RXBUF);
    start   = wr_tx && eng_idle;
    cfg_d.lsb_first  = host_wdata[CB_ORDER];
    cfg_d.dly_sel    = host_wdata[CB_DLY_HI:CB_DLY_LO];
    cfg_d.open_drain = host_wdata[CB_OD];
    full_en = xfer_done || rd_rx;
    full_d  = xfer_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf_q <= '0;
      rxbuf_q <= '0;
      cfg_q   <= '0;
      full_q  <= 1'b0;
    end else begin
      if (start)     txbuf_q <= host_wdata;
      if (xfer_done) rxbuf_q <= rx_byte;
      if (wr_ctl)    cfg_q   <= cfg_d;
      if (full_en)   full_q  <= full_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      A_RXBUF: host_rdata = rxbuf_q;
      A_TXBUF: host_rdata = txbuf_q;
      A_CTRL: begin
        host_rdata[CB_ORDER]            = cfg_q.lsb_first;
        host_rdata[CB_DLY_HI:CB_DLY_LO] = cfg_q.dly_sel;
        host_rdata[CB_OD]               = cfg_q.open_drain;
        host_rdata[CB_FULL]             = full_q;
      end
      default: host_rdata = '0;
    endcase
  end

  assign tx_byte = txbuf_q;
  assign cfg     = cfg_q;
  assign rx_full = full_q;

endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_eng_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DLY_UNIT = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  eng_cfg_t cfg_in,
  output eng_cfg_t cfg_act,
  output logic     idle,
  output logic     busy,
  output logic     sclk,
  output logic     sample_en,
  output logic     shift_en,
  output logic     done
);

  localparam int BC_W = $clog2(DW);
  localparam int DC_W = $clog2(4 * DLY_UNIT);

  eng_state_t      state_q, state_d;
  logic [BC_W-1:0] bit_q, bit_d;
  logic [DC_W-1:0] dly_q, dly_d;
  logic            sclk_q, sclk_d;
  eng_cfg_t        cfg_q;
  logic [2:0]      dsel_p1;
  logic [DC_W-1:0] dly_load;
  logic            last_bit;

  always_comb begin
    sample_en = (state_q == ST_SHIFT) && !sclk_q;
    shift_en  = (state_q == ST_SHIFT) && sclk_q;
    last_bit  = (bit_q == BC_W'(DW - 1));
    done      = (state_q == ST_HOLD) && (dly_q == '0);
    dsel_p1   = {1'b0, cfg_q.dly_sel} + 3'd1;
    dly_load  = DC_W'(int'(dsel_p1) * DLY_UNIT - 1);
  end

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    dly_d   = dly_q;
    sclk_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SHIFT;
          bit_d   = '0;
        end
      end
      ST_SHIFT: begin
        sclk_d = !sclk_q;
        if (sample_en) begin
          if (last_bit) begin
            state_d = ST_HOLD;
            dly_d   = dly_load;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (dly_q == '0) state_d = ST_IDLE;
        else             dly_d   = dly_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      dly_q   <= '0;
      sclk_q  <= 1'b0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      dly_q   <= dly_d;
      sclk_q  <= sclk_d;
      if (start && (state_q == ST_IDLE)) cfg_q <= cfg_in;
    end
  end

  assign cfg_act = cfg_q;
  assign idle    = (state_q == ST_IDLE);
  assign busy    = (state_q == ST_SHIFT);
  assign sclk    = sclk_q;

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          lsb_first,
  input  logic          sample_en,
  input  logic          shift_en,
  input  logic          sdi,
  output logic          tx_bit,
  output logic [DW-1:0] rx_byte
);

  logic [DW-1:0] tx_q, tx_d, rx_q, rx_d;
  logic          tx_en, rx_en;

  always_comb begin
    tx_en = load || shift_en;
    rx_en = sample_en;
    if (load)           tx_d = load_data;
    else if (lsb_first) tx_d = tx_q >> 1;
    else                tx_d = tx_q << 1;
    if (lsb_first) rx_d = {sdi, rx_q[DW-1:1]};
    else           rx_d = {rx_q[DW-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (tx_en) tx_q <= tx_d;
      if (rx_en) rx_q <= rx_d;
    end
  end

  assign tx_bit  = lsb_first ? tx_q[0] : tx_q[DW-1];
  assign rx_byte = rx_q;

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DLY_UNIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic              sdi,
  output logic              sclk,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic              rx_full
);

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic          eng_idle, start, done, sample_en, shift_en, tx_bit, drive_tx;
  logic [DW-1:0] tx_byte, rx_byte;
  eng_cfg_t      cfg_reg, cfg_act;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  spi_host_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_idle(eng_idle), .xfer_done(done), .rx_byte(rx_byte),
    .start(start), .tx_byte(tx_byte), .cfg(cfg_reg), .rx_full(rx_full)
  );

  spi_seq #(.DW(DW), .DLY_UNIT(DLY_UNIT)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .cfg_in(cfg_reg),
    .cfg_act(cfg_act), .idle(eng_idle), .busy(busy), .sclk(sclk),
    .sample_en(sample_en), .shift_en(shift_en), .done(done)
  );

  spi_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .load(start), .load_data(host_wdata),
    .lsb_first(cfg_act.lsb_first), .sample_en(sample_en), .shift_en(shift_en),
    .sdi(sdi), .tx_bit(tx_bit), .rx_byte(rx_byte)
  );

  // keep the last bit on the wire until the clock has fallen
  always_comb begin
    drive_tx = busy || sclk;
    sdo      = drive_tx ? tx_bit : 1'b1;
    sdo_oe   = cfg_act.open_drain ? !sdo : 1'b1;
  end

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          sclk,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          rx_full,
  input logic          od_mode,
  input logic [DW-1:0] txbuf
);

  AST_OD_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (od_mode && sdo_oe) |-> !sdo); // R8

  AST_PP_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !od_mode |-> sdo_oe); // R8

  AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdo)); // R3

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$fell(busy)) |-> !sclk); // R3

  AST_FULL_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> !busy); // R6

  AST_TXBUF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(txbuf)); // R9

endmodule

bind spi_shift_engine spi_eng_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .busy(busy), .sclk(sclk), .sdo(sdo),
  .sdo_oe(sdo_oe), .rx_full(rx_full), .od_mode(cfg_act.open_drain),
  .txbuf(tx_byte)
);

// File: tb/spi_shift_engine_test.sv
module spi_shift_engine_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr, host_rd, sdi;
  logic [1:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic       sclk, sdo, sdo_oe, busy, rx_full;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  spi_shift_engine uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sdi(sdi), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy),
    .rx_full(rx_full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input bit clr, output logic [7:0] d);
    host_addr = a; host_rd = clr;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 busy", busy, 0);
    chk("R1 sclk", sclk, 0);
    chk("R1 sdo", sdo, 1);
    chk("R1 sdo_oe", sdo_oe, 1);
    chk("R1 rx_full", rx_full, 0);
    rd_reg(2'd2, 0, v); chk("R1 status", v, 8'h00);
    rd_reg(2'd0, 0, v); chk("R1 rxbuf", v, 8'h00);
  endtask

  // one full transfer; poke injects writes mid-shift and during settle
  task automatic t_xfer(input logic [7:0] ctl, input logic [7:0] tx,
                        input logic [7:0] rx, input bit poke);
    int n, e, idx;
    bit lsb, od;
    logic [7:0] v;
    lsb = ctl[7]; od = ctl[3];
    n = (int'(ctl[6:5]) + 1) * 8;
    wr_reg(2'd2, ctl);
    wr_reg(2'd1, tx);               // write edge E0
    chk("R2 busy after start", busy, 1);
    for (int k = 0; k < 8; k++) begin
      idx = lsb ? k : 7 - k;
      sdi = rx[idx];
      chk("R4 sdo bit", sdo, tx[idx]);
      chk("R3 sclk low", sclk, 0);
      chk("R8 sdo_oe", sdo_oe, od ? !sdo : 1'b1);
      if (poke && k == 3) begin
        host_addr = 2'd1; host_wdata = ~tx; host_wr = 1'b1;
      end
      @(negedge clk);
      host_wr = 1'b0;
      chk("R3 sclk high", sclk, 1);
      chk("R3 sdo stable high", sdo, tx[idx]);
      chk("R2 busy window", busy, k == 7 ? 0 : 1);
      @(negedge clk);
    end
    e = 16;
    chk("R5 sdo idle in settle", sdo, 1);
    chk("R5 sclk low in settle", sclk, 0);
    if (poke) begin
      wr_reg(2'd1, ~tx);
      e = 17;
    end
    repeat (14 + n - e) @(negedge clk);
    chk("R5 not yet complete", rx_full, 0);
    @(negedge clk);
    chk("R5 complete at delay", rx_full, 1);
    rd_reg(2'd0, 0, v); chk("R6 rxbuf R4 order", v, rx);
    rd_reg(2'd2, 0, v); chk("R6 status full", v[0], 1);
    if (poke) begin
      rd_reg(2'd1, 0, v); chk("R9 txbuf unchanged", v, tx);
    end
    rd_reg(2'd0, 1, v);
    chk("R7 rx_full cleared", rx_full, 0);
    rd_reg(2'd2, 0, v); chk("R7 status cleared", v[0], 0);
  endtask

  task automatic t_status();
    logic [7:0] v;
    wr_reg(2'd2, 8'hFF);
    rd_reg(2'd2, 0, v); chk("R10 status readback", v, 8'hE8);
    chk("R10 no start on ctrl write", busy, 0);
    wr_reg(2'd2, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0; sdi = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_xfer(8'h00, 8'hA5, 8'h3C, 0);   // MSB first, 8 clocks, push-pull
    t_xfer(8'h80, 8'h1E, 8'hB4, 0);   // LSB first
    t_xfer(8'h20, 8'hC3, 8'h5A, 0);   // 16 clocks
    t_xfer(8'hC0, 8'h71, 8'h8E, 0);   // 24 clocks, LSB first
    t_xfer(8'h60, 8'h0F, 8'hF0, 0);   // 32 clocks
    t_xfer(8'h88, 8'h6A, 8'h95, 0);   // open-drain, LSB first
    t_xfer(8'h08, 8'hD2, 8'h2D, 0);   // open-drain, MSB first
    t_xfer(8'h00, 8'h99, 8'h66, 1);   // writes during transfer ignored
    t_xfer(8'h00, 8'h42, 8'h81, 0);   // next transfer still normal
    t_status();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule